// File: doc/BRIEF.md
# Hard-Sector Timing and Status Tracker

This block follows the rotation of a hard-sectored floppy disk in the selected drive. It takes one-cycle pulses for the sector hole and the index hole, which are already debounced, and a one-cycle microsecond tick. From these it keeps the timing status that the disk controller reports to software:

- a sticky sector flag;
- an indication that the index hole went past during the sector that just ended;
- a fixed-length window that opens at each sector hole;
- the current sector number on a track of ten sectors;
- the motor-on state.

The sector number is found by counting physical sector holes. The index hole sets the count back to zero at the first sector hole that follows it. The motors turn off by themselves when a set number of sector holes go by with no motor command and no status read that carries the motor code.

Command strobes clear the sector flag, turn the motors on, mark a motor-coded status read, and reset the block. All pins are plain level or pulse signals. There is no data stream, so the block has no handshake. Every output is a register and changes on the clock edge that samples the pulse causing the change.

Top module: `hs_timing_tracker`

## Requirements
- R1: `sector_flag` goes to 1 on the edge that samples `sector_hole`. It stays 1 until an edge that samples `clr_sector_flag` without `sector_hole`. If both pulses come in the same cycle, the flag stays set.
- R2: At each sector hole, `index_seen` takes the value 1 if an index pulse came after the previous sector hole (including an index pulse in the same cycle as this hole), and 0 otherwise. Between sector holes, `index_seen` holds its value.
- R3: `window` goes high on the edge that samples `sector_hole`. It stays high for exactly `WINDOW_US` microsecond ticks (default 96), counting the ticks sampled after that edge. A new sector hole starts the window again from the full length.
- R4: At a sector hole that R2 marks as having an index, `sector_num` becomes 0.
- R5: At any other sector hole, `sector_num` goes up by one and wraps from `NUM_SECTORS-1` (9 by default) to 0. `sector_num` is a 4-bit unsigned value and is always below `NUM_SECTORS`.
- R6: `motor_on_cmd` sets `motor_on` to 1 on the next edge. `motor_on` never rises without that command.
- R7: While the motor is on, it turns off after `MOTOR_OFF_HOLES` sector holes in a row with no `motor_on_cmd` and no `motor_status_read`. Either strobe starts the count again, and wins over a hole in the same cycle.
- R8: The active-low `rst_n`, and `ctrl_reset` on a clock edge, clear `sector_flag`, `index_seen`, `sector_num`, `window` and `motor_on`. `ctrl_reset` overrides every other input in its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| sector_hole | input | 1 | One-cycle pulse per sector hole |
| index_hole | input | 1 | One-cycle pulse per index hole |
| clr_sector_flag | input | 1 | Command strobe: clear the sector flag |
| motor_on_cmd | input | 1 | Command strobe: turn the motors on |
| motor_status_read | input | 1 | Strobe: a status read carrying the motor code |
| ctrl_reset | input | 1 | Command strobe: controller reset |
| sector_flag | output | 1 | Sticky sector-hole flag |
| index_seen | output | 1 | Index hole seen during the previous sector |
| window | output | 1 | Start-of-sector window |
| sector_num | output | 4 | Current sector position |
| motor_on | output | 1 | Motors running |

## Verification
Three hole patterns are used, each to show a different thing.

- **Holes with no index:** the count must run 0 to 9 and wrap. With the motor limit set small, this pattern also shows the motor turning off after the set number of holes.
- **An index pulse in each revolution, at varying places:** these include the cycle of a hole and the middle of a sector. They tell a counter that resynchronises at the index hole apart from one that only wraps, and they show whether `index_seen` is tied to the right interval.
- **Holes closer together than the window, and random strobes:** these show that the window restarts. They also exercise the priority between set and clear, between the motor strobes and a hole, and of the controller reset.

// File: rtl/hs_timing_pkg.sv
package hs_timing_pkg;
  localparam int SECTOR_W = 4;
  typedef logic [SECTOR_W-1:0] sector_t;

  function automatic sector_t next_sector(input sector_t cur, input int unsigned count);
    if (32'(cur) + 1 >= count) return '0;
    return cur + sector_t'(1);
  endfunction
endpackage

// File: rtl/hs_sector_pos.sv
module hs_sector_pos
  import hs_timing_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 10
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sector_hole,
  input  logic    index_hole,
  input  logic    clr_sector_flag,
  input  logic    ctrl_reset,
  output logic    sector_flag,
  output logic    index_seen,
  output sector_t sector_num
);
  logic    idx_pend_q;
  logic    idx_this;
  sector_t num_d;

  assign idx_this = idx_pend_q | index_hole;

  always_comb begin
    num_d = sector_num;
    if (sector_hole) begin
      if (idx_this) num_d = '0;
      else          num_d = next_sector(sector_num, NUM_SECTORS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector_flag <= 1'b0;
      index_seen  <= 1'b0;
      idx_pend_q  <= 1'b0;
      sector_num  <= '0;
    end else if (ctrl_reset) begin
      sector_flag <= 1'b0;
      index_seen  <= 1'b0;
      idx_pend_q  <= 1'b0;
      sector_num  <= '0;
    end else begin
      if (sector_hole)          sector_flag <= 1'b1;
      else if (clr_sector_flag) sector_flag <= 1'b0;
      if (sector_hole) begin
        index_seen <= idx_this;
        idx_pend_q <= 1'b0;
      end else if (index_hole) begin
        idx_pend_q <= 1'b1;
      end
      sector_num <= num_d;
    end
  end

  assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_hole && !ctrl_reset) |=> sector_flag);
  assert_flag_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sector_flag && !sector_hole) |=> !sector_flag);
  assert_sync_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_hole && !ctrl_reset) |=> (!index_seen || sector_num == '0));
  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sector_num) < NUM_SECTORS);
  assert_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reset |=> (!sector_flag && !index_seen && sector_num == '0));
endmodule

// File: rtl/hs_window_timer.sv
module hs_window_timer #(
  parameter int unsigned WINDOW_US = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic sector_hole,
  input  logic ctrl_reset,
  output logic window
);
  localparam int CW = $clog2(WINDOW_US + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       left_q <= '0;
    else if (ctrl_reset)              left_q <= '0;
    else if (sector_hole)             left_q <= CW'(WINDOW_US);
    else if (us_tick && left_q != '0) left_q <= left_q - CW'(1);
  end

  assign window = (left_q != '0);

  assert_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_hole && !ctrl_reset) |=> window);
  assert_close_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(window) |-> ($past(us_tick) || $past(ctrl_reset)));
endmodule

// File: rtl/hs_motor_keeper.sv
module hs_motor_keeper #(
  parameter int unsigned MOTOR_OFF_HOLES = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sector_hole,
  input  logic motor_on_cmd,
  input  logic motor_status_read,
  input  logic ctrl_reset,
  output logic motor_on
);
  localparam int IW = $clog2(MOTOR_OFF_HOLES + 1);
  logic [IW-1:0] idle_q;
  logic          expire;

  assign expire = (idle_q == IW'(MOTOR_OFF_HOLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      motor_on <= 1'b0;
      idle_q   <= '0;
    end else if (ctrl_reset) begin
      motor_on <= 1'b0;
      idle_q   <= '0;
    end else if (motor_on_cmd) begin
      motor_on <= 1'b1;
      idle_q   <= '0;
    end else if (motor_status_read) begin
      idle_q   <= '0;
    end else if (sector_hole && motor_on) begin
      if (expire) begin
        motor_on <= 1'b0;
        idle_q   <= '0;
      end else begin
        idle_q   <= idle_q + IW'(1);
      end
    end
  end

  assert_rise_needs_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(motor_on) |-> $past(motor_on_cmd));
  assert_cmd_turns_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_on_cmd && !ctrl_reset) |=> motor_on);
  assert_off_only_on_hole_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(motor_on) |-> ($past(ctrl_reset) || $past(sector_hole)));
  assert_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reset |=> !motor_on);
endmodule

// File: rtl/hs_timing_tracker.sv
module hs_timing_tracker
  import hs_timing_pkg::*;
#(
  parameter int unsigned NUM_SECTORS     = 10,
  parameter int unsigned WINDOW_US       = 96,
  parameter int unsigned MOTOR_OFF_HOLES = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       sector_hole,
  input  logic       index_hole,
  input  logic       clr_sector_flag,
  input  logic       motor_on_cmd,
  input  logic       motor_status_read,
  input  logic       ctrl_reset,
  output logic       sector_flag,
  output logic       index_seen,
  output logic       window,
  output logic [3:0] sector_num,
  output logic       motor_on
);
  sector_t num_w;

  hs_sector_pos #(.NUM_SECTORS(NUM_SECTORS)) u_pos (
    .clk(clk), .rst_n(rst_n), .sector_hole(sector_hole), .index_hole(index_hole),
    .clr_sector_flag(clr_sector_flag), .ctrl_reset(ctrl_reset),
    .sector_flag(sector_flag), .index_seen(index_seen), .sector_num(num_w)
  );

  hs_window_timer #(.WINDOW_US(WINDOW_US)) u_win (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .sector_hole(sector_hole),
    .ctrl_reset(ctrl_reset), .window(window)
  );

  hs_motor_keeper #(.MOTOR_OFF_HOLES(MOTOR_OFF_HOLES)) u_mot (
    .clk(clk), .rst_n(rst_n), .sector_hole(sector_hole), .motor_on_cmd(motor_on_cmd),
    .motor_status_read(motor_status_read), .ctrl_reset(ctrl_reset), .motor_on(motor_on)
  );

  assign sector_num = num_w;
endmodule

// File: tb/hs_timing_tracker_tb.sv
module hs_timing_tracker_tb;
  localparam int NS  = 10;
  localparam int WUS = 96;
  localparam int LIM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0, sector_hole = 1'b0, index_hole = 1'b0;
  logic clr_sector_flag = 1'b0, motor_on_cmd = 1'b0, motor_status_read = 1'b0, ctrl_reset = 1'b0;
  logic sector_flag, index_seen, window, motor_on;
  logic [3:0] sector_num;

  int total = 0, failed = 0, tcnt = 0;

  always #5 clk = ~clk;

  hs_timing_tracker #(.NUM_SECTORS(NS), .WINDOW_US(WUS), .MOTOR_OFF_HOLES(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .sector_hole(sector_hole),
    .index_hole(index_hole), .clr_sector_flag(clr_sector_flag), .motor_on_cmd(motor_on_cmd),
    .motor_status_read(motor_status_read), .ctrl_reset(ctrl_reset),
    .sector_flag(sector_flag), .index_seen(index_seen), .window(window),
    .sector_num(sector_num), .motor_on(motor_on)
  );

  // behavioural reference model
  int m_flag, m_idx, m_pend, m_num, m_win, m_mot, m_idle;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || ctrl_reset) begin
      m_flag = 0; m_idx = 0; m_pend = 0; m_num = 0; m_win = 0; m_mot = 0; m_idle = 0;
    end else begin
      if (sector_hole) m_flag = 1;
      else if (clr_sector_flag) m_flag = 0;
      if (sector_hole) begin
        m_idx  = (m_pend != 0 || index_hole) ? 1 : 0;
        m_num  = m_idx ? 0 : (m_num + 1) % NS;
        m_pend = 0;
      end else if (index_hole) m_pend = 1;
      if (sector_hole) m_win = WUS;
      else if (us_tick && m_win > 0) m_win = m_win - 1;
      if (motor_on_cmd) begin m_mot = 1; m_idle = 0; end
      else if (motor_status_read) m_idle = 0;
      else if (sector_hole && m_mot != 0) begin
        m_idle = m_idle + 1;
        if (m_idle == LIM) begin m_mot = 0; m_idle = 0; end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 sector_flag", sector_flag, m_flag);
    chk("R2 index_seen", index_seen, m_idx);
    chk("R3 window", window, (m_win > 0) ? 1 : 0);
    chk("R4/R5 sector_num", sector_num, m_num);
    chk("R6/R7 motor_on", motor_on, m_mot);
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic cyc(input bit h, input bit i, input bit c, input bit m, input bit r, input bit x);
    @(negedge clk);
    compare_all();
    sector_hole = h; index_hole = i; clr_sector_flag = c;
    motor_on_cmd = m; motor_status_read = r; ctrl_reset = x;
    us_tick = (tcnt % 3 == 0); tcnt++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic hole(input bit with_idx);
    cyc(1, with_idx, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_500_000;
    total++; failed++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R8 reset state
    chk("R8 reset flag", sector_flag, 0);
    chk("R8 reset sector_num", sector_num, 0);
    chk("R8 reset motor", motor_on, 0);
    chk("R8 reset window", window, 0);

    // R6 motor on
    cyc(0, 0, 0, 1, 0, 0);
    idle(1);
    chk("R6 motor on after command", motor_on, 1);

    // no index: count and wrap (R5), window length (R3), motor timeout (R7)
    for (int s = 1; s <= 10; s++) begin
      hole(0);
      if (s == 1) chk("R3 window open", window, 1);
      if (s == 9) chk("R5 count reaches 9", sector_num, 9);
      if (s == 10) chk("R5 wrap to 0", sector_num, 0);
      if (s == LIM) chk("R7 motor off after limit", motor_on, 0);
      idle(3 * WUS + 20);
      if (s == 1) chk("R3 window closed", window, 0);
    end

    // R1 clear, and set winning over clear
    cyc(0, 0, 1, 0, 0, 0); idle(1);
    chk("R1 cleared", sector_flag, 0);
    cyc(1, 0, 1, 0, 0, 0); idle(1);
    chk("R1 set wins", sector_flag, 1);

    // index resynchronisation (R2, R4), index at several places
    cyc(0, 0, 0, 1, 0, 0);
    for (int rev = 0; rev < 3; rev++) begin
      for (int s = 0; s < NS; s++) begin
        if (rev == 0 && s == 4) begin idle(30); cyc(0, 1, 0, 0, 0, 0); end
        if (rev == 1 && s == 7) begin cyc(1, 1, 0, 0, 0, 0); idle(1);
          chk("R4 zero after index in hole cycle", sector_num, 0);
          chk("R2 index with hole", index_seen, 1); idle(50); continue; end
        if (rev == 2 && s == 2) begin idle(10); cyc(0, 1, 0, 0, 1, 0); end
        hole(0);
        idle(50);
        if (s % 3 == 0) cyc(0, 0, 0, 0, 1, 0);
      end
    end

    // holes closer than the window: restart (R3); motor keep-alive (R7)
    cyc(0, 0, 0, 1, 0, 0);
    for (int s = 0; s < 12; s++) begin
      hole(0); idle(3 * WUS - 40);
      chk("R3 window still open on restart", window, 1);
      cyc(0, 0, 0, 0, (s % 2 == 0), 0);
    end
    chk("R7 motor kept on by status reads", motor_on, 1);

    // R8 controller reset mid-run
    cyc(1, 0, 0, 1, 0, 1); idle(1);
    chk("R8 ctrl reset flag", sector_flag, 0);
    chk("R8 ctrl reset motor", motor_on, 0);
    chk("R8 ctrl reset window", window, 0);

    // random strobes
    for (int k = 0; k < 20000; k++) begin
      cyc(($urandom % 60) == 0, ($urandom % 300) == 0, ($urandom % 40) == 0,
          ($urandom % 500) == 0, ($urandom % 400) == 0, ($urandom % 3000) == 0);
    end
    idle(2);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule